// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host read and write a bank of sixteen 16-bit control registers over a serial link with four signals: an active-low select, a clock, data in and data out. Every access is one frame of exactly 24 serial clocks. The first byte is a command: a direction bit, a two-bit key that must equal `10`, a four-bit register address and one ignored bit. The remaining sixteen bits carry the register word, MSB first. The data output comes with an enable, so a pad outside the block can put it into high impedance. This allows data in and data out to share one wire.

The serial pins are sampled by a fast system clock. The serial clock must therefore run well below that clock; four system clocks or more per serial half-period is enough. Rising serial edges capture data in, and falling serial edges move data out. A frame cut short is dropped. A frame held longer than 24 clocks still commits its write at clock 24, or keeps the last read bit on the line. A mode pin holds the whole bank at its defaults while it is high. Every register is visible on a flat parallel bus, and a one-cycle strobe marks each committed write.

Top module: `sra_top`

## Requirements
- R1: After reset, register i holds i*0x0101, sdoOe is low and wrStrobe is low.
- R2: Data in is sampled on rising serial clock edges. Frame bit 1 is the direction (0 write, 1 read). Bits 2-3 are the key. Bits 4-7 are the address, MSB first. Bit 8 is ignored. Bits 9-24 are the data, MSB first.
- R3: A valid write updates the addressed register when the 24th rising edge is seen. Register i appears on regBus[16i+15:16i].
- R4: During a read, sdoOe rises after the 8th falling serial edge, and sdo then shows the register MSB. Each following falling edge moves to the next lower bit. sdoOe is low during writes, before that edge, and whenever select is high.
- R5: If select rises before the 24th rising edge, no register changes.
- R6: A write frame longer than 24 clocks commits the bits of clock 9 to 24 and ignores any later bits.
- R7: A read frame longer than 24 clocks keeps driving D0 until select rises.
- R8: Addresses whose bit in VALID_MASK is clear (address 14 by default) read as zero, and writes to them are ignored.
- R9: A frame whose key is not `10` is ignored when it is a write, and reads back as zero when it is a read.
- R10: While modeDefault is high, every register holds its default and writes are ignored. The defaults stay in place after the pin falls.
- R11: Each committed write pulses wrStrobe for one system clock, with wrIndex set to the address. An ignored or aborted write gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| modeDefault | input | 1 | High holds all registers at their defaults |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for sdo |
| regBus | output | 256 | All registers, register i at bits 16i+15:16i |
| wrStrobe | output | 1 | One-cycle pulse on a committed write |
| wrIndex | output | 4 | Address of the committed write |

## Verification
The bench runs full 24-clock writes and reads with varied data words, including one with the ignored bit set, to show that the fields are decoded at the right positions. Frames of 20 and 30 clocks show the difference between an abort and an overlong frame. An overlong read also shows that D0 is held on the line. Frames with a bad key and frames to an unimplemented address show that each invalid case is blocked on its own. Toggling the mode pin around a write shows that the defaults win and that they persist after the pin falls.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int CMD_LEN = 8;
  localparam int ADDR_W  = 4;

  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic commit;
    logic loadRead;
    logic shiftOut;
  } sraCtl_t;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
#(
  parameter int FRAME_LEN = 24,
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output sraCtl_t ctl,
  output logic    sdiS,
  output logic    holdEdge
);
  logic csQ, sclkQ, sclkQQ, sdiQ;
  logic [CW-1:0] bitCnt;
  logic riseE, fallE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ    <= 1'b1;
      sclkQ  <= 1'b0;
      sclkQQ <= 1'b0;
      sdiQ   <= 1'b0;
    end else begin
      csQ    <= csN;
      sclkQ  <= sclk;
      sclkQQ <= sclkQ;
      sdiQ   <= sdi;
    end
  end

  assign riseE = sclkQ & ~sclkQQ & ~csQ;
  assign fallE = ~sclkQ & sclkQQ & ~csQ;
  assign sdiS  = sdiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  bitCnt <= '0;
    else if (csQ)                               bitCnt <= '0;
    else if (riseE && bitCnt != CW'(FRAME_LEN)) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    ctl.clear    = csQ;
    ctl.shiftIn  = riseE && (bitCnt < CW'(FRAME_LEN));
    ctl.commit   = riseE && (bitCnt == CW'(FRAME_LEN - 1));
    ctl.loadRead = fallE && (bitCnt == CW'(CMD_LEN));
    ctl.shiftOut = fallE && (bitCnt > CW'(CMD_LEN)) && (bitCnt < CW'(FRAME_LEN));
    holdEdge     = fallE && (bitCnt == CW'(FRAME_LEN));
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CW'(FRAME_LEN)) else $error("bit counter overran"); // R6
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.commit, ctl.loadRead, ctl.shiftOut})) else $error("edge strobes overlap"); // R2
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csQ |=> (bitCnt == '0)) else $error("count survived select release"); // R5
endmodule

// File: rtl/sra_datapath.sv
module sra_datapath
  import sra_pkg::*;
#(
  parameter int REG_W = 16,
  parameter logic [(1<<ADDR_W)-1:0] VALID_MASK = 16'hBFFF,
  parameter logic [REG_W-1:0] DEFAULT_STEP = 16'h0101,
  localparam int NUM_REGS  = 1 << ADDR_W,
  localparam int FRAME_LEN = CMD_LEN + REG_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sraCtl_t                   ctl,
  input  logic                      sdiS,
  input  logic                      modeDefault,
  output logic                      sdo,
  output logic                      sdoOe,
  output logic [NUM_REGS*REG_W-1:0] regBus,
  output logic                      wrStrobe,
  output logic [ADDR_W-1:0]         wrIndex
);
  logic [FRAME_LEN-2:0] frameSr;
  logic [FRAME_LEN-1:0] frameNext;
  logic [CMD_LEN-1:0]   wCmd, rCmd;
  logic [ADDR_W-1:0]    wAddr, rAddr;
  logic [REG_W-1:0]     wData;
  logic                 wGo, rOk;
  logic [REG_W-1:0]     regFile [NUM_REGS];
  logic [REG_W-1:0]     outSr;
  logic                 sdoEn;
  logic [NUM_REGS*REG_W-1:0] defImage;

  assign frameNext = {frameSr, sdiS};
  assign wCmd  = frameNext[FRAME_LEN-1 -: CMD_LEN];
  assign wAddr = wCmd[ADDR_W:1];
  assign wData = frameNext[REG_W-1:0];
  assign wGo   = ctl.commit && !wCmd[CMD_LEN-1] && (wCmd ==? 8'b?10?????)
                 && VALID_MASK[wAddr] && !modeDefault;

  assign rCmd  = frameSr[CMD_LEN-1:0];
  assign rAddr = rCmd[ADDR_W:1];
  assign rOk   = (rCmd ==? 8'b?10?????) && VALID_MASK[rAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            frameSr <= '0;
    else if (ctl.shiftIn) frameSr <= frameNext[FRAME_LEN-2:0];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] DEF = REG_W'(i) * DEFAULT_STEP;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 regFile[i] <= DEF;
      else if (modeDefault)                      regFile[i] <= DEF;
      else if (wGo && wAddr == ADDR_W'(i))       regFile[i] <= wData;
    end
    assign regBus[i*REG_W +: REG_W]   = regFile[i];
    assign defImage[i*REG_W +: REG_W] = DEF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
    end else begin
      wrStrobe <= wGo;
      if (wGo) wrIndex <= wAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoEn <= 1'b0;
      outSr <= '0;
    end else if (ctl.clear) begin
      sdoEn <= 1'b0;
    end else if (ctl.loadRead && rCmd[CMD_LEN-1]) begin
      sdoEn <= 1'b1;
      outSr <= rOk ? regFile[rAddr] : '0;
    end else if (ctl.shiftOut && sdoEn) begin
      outSr <= {outSr[REG_W-2:0], 1'b0};
    end
  end

  assign sdo   = outSr[REG_W-1];
  assign sdoOe = sdoEn;

  AST_MODE_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    modeDefault |=> (regBus == defImage)) else $error("register left default in mode"); // R10
  AST_STROBE_VALID_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> VALID_MASK[wrIndex]) else $error("strobe for unimplemented address"); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe) else $error("write strobe longer than one cycle"); // R11
endmodule

// File: rtl/sra_top.sv
module sra_top
  import sra_pkg::*;
#(
  parameter int REG_W = 16,
  parameter logic [(1<<ADDR_W)-1:0] VALID_MASK = 16'hBFFF,
  parameter logic [REG_W-1:0] DEFAULT_STEP = 16'h0101,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic                      modeDefault,
  output logic                      sdo,
  output logic                      sdoOe,
  output logic [NUM_REGS*REG_W-1:0] regBus,
  output logic                      wrStrobe,
  output logic [ADDR_W-1:0]         wrIndex
);
  sraCtl_t ctl;
  logic    sdiS, holdEdge;

  sra_ctrl #(.FRAME_LEN(CMD_LEN + REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .ctl(ctl), .sdiS(sdiS), .holdEdge(holdEdge)
  );

  sra_datapath #(.REG_W(REG_W), .VALID_MASK(VALID_MASK), .DEFAULT_STEP(DEFAULT_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiS(sdiS), .modeDefault(modeDefault),
    .sdo(sdo), .sdoOe(sdoOe), .regBus(regBus), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clear && $past(ctl.clear)) |-> !sdoOe) else $error("output enabled while idle"); // R4
  AST_HOLD_LAST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    holdEdge |=> $stable(sdo)) else $error("last bit not held"); // R7
endmodule

// File: tb/sim_sra_top.sv
module sim_sra_top;
  typedef struct {
    string       tag;
    logic [15:0] val;
  } item_t;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0, modeDefault = 1'b0;
  logic sdo, sdoOe, wrStrobe;
  logic [255:0] regBus;
  logic [3:0] wrIndex;

  int errors = 0, checks = 0, strobeCnt = 0;
  logic [3:0] lastIdx = '0;
  logic [15:0] model [16];
  item_t expQ[$], obsQ[$];

  sra_top u0 (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .modeDefault(modeDefault), .sdo(sdo), .sdoOe(sdoOe), .regBus(regBus),
    .wrStrobe(wrStrobe), .wrIndex(wrIndex));

  always #10 clk = ~clk;

  always @(negedge clk) if (rstN && wrStrobe) begin
    strobeCnt++;
    lastIdx = wrIndex;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected and observed read words and compares them
  initial forever begin
    @(negedge clk);
    while (expQ.size() > 0 && obsQ.size() > 0) begin
      item_t e, o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      chk({e.tag, " read word"}, {16'h0, o.val}, {16'h0, e.val});
    end
  end

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] f, input int nClk, output logic [15:0] rd,
                      output int oeEarly, output int oeLate, output logic tailOk);
    rd = '0; oeEarly = 0; oeLate = 0; tailOk = 1'b1;
    csN = 1'b0;
    half();
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 24) ? f[23-i] : 1'b1;
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      if (i < 7 && sdoOe) oeEarly++;
      if (i >= 7 && sdoOe) oeLate++;
      if (i >= 7 && i <= 22) rd = {rd[14:0], sdo};
      if (i > 22 && (sdo !== rd[0] || sdoOe !== 1'b1)) tailOk = 1'b0;
      @(negedge clk);
    end
    csN = 1'b1;
    sdi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic rw, input logic [1:0] key,
                                     input logic [3:0] a, input logic dc, input logic [15:0] d);
    return {rw, key, a, dc, d};
  endfunction

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d, input int nClk,
                          input logic [1:0] key, input logic dc);
    logic [15:0] rd; int e, l; logic t;
    xfer(mk(1'b0, key, a, dc, d), nClk, rd, e, l, t);
    chk("R4 oe low in write", e + l, 0);
  endtask

  task automatic readReg(input string tag, input logic [3:0] a, input logic [15:0] exp,
                         input int nClk, input logic [1:0] key);
    logic [15:0] rd; int e, l; logic t;
    expQ.push_back('{tag: tag, val: exp});
    xfer(mk(1'b1, key, a, 1'b0, 16'h0), nClk, rd, e, l, t);
    obsQ.push_back('{tag: tag, val: rd});
    chk("R4 oe not before 8th fall", e, 0);
    chk("R4 oe count after 8th fall", l, nClk - 7);
    chk("R4 oe low after select", {31'h0, sdoOe}, 0);
    if (nClk > 24) chk("R7 D0 held", {31'h0, t}, 1);
  endtask

  task automatic chkReg(input string tag, input int a);
    chk(tag, {16'h0, regBus[a*16 +: 16]}, {16'h0, model[a]});
  endtask

  initial begin
    int sc;
    for (int i = 0; i < 16; i++) model[i] = 16'(i * 257);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 16; i++) chkReg("R1 default", i);
    chk("R1 oe", {31'h0, sdoOe}, 0);
    chk("R1 strobe", {31'h0, wrStrobe}, 0);

    // R2 R3 R11 plain write, ignored bit set
    sc = strobeCnt;
    writeReg(4'd3, 16'hA55A, 24, 2'b10, 1'b1);
    model[3] = 16'hA55A;
    chkReg("R3 write addr3", 3);
    chk("R11 strobe count", strobeCnt, sc + 1);
    chk("R11 strobe index", {28'h0, lastIdx}, 3);

    readReg("R4 addr3", 4'd3, 16'hA55A, 24, 2'b10);
    readReg("R2 default addr9", 4'd9, 16'h0909, 24, 2'b10);

    // R5 aborted write
    sc = strobeCnt;
    writeReg(4'd5, 16'hDEAD, 20, 2'b10, 1'b0);
    chkReg("R5 aborted write", 5);
    chk("R11 no strobe on abort", strobeCnt, sc);

    // R6 long write
    writeReg(4'd7, 16'h1234, 30, 2'b10, 1'b0);
    model[7] = 16'h1234;
    chkReg("R6 long write", 7);
    chk("R11 strobe index long", {28'h0, lastIdx}, 7);
    readReg("R7 long read", 4'd7, 16'h1234, 30, 2'b10);
    readReg("R7 long read odd", 4'd9, 16'h0909, 28, 2'b10);

    // R8 invalid address
    sc = strobeCnt;
    writeReg(4'd14, 16'hFFFF, 24, 2'b10, 1'b0);
    chkReg("R8 invalid write", 14);
    chk("R8 no strobe", strobeCnt, sc);
    readReg("R8 invalid read", 4'd14, 16'h0000, 24, 2'b10);

    // R9 bad key
    writeReg(4'd2, 16'hBEEF, 24, 2'b01, 1'b0);
    chkReg("R9 bad key write", 2);
    chk("R9 no strobe", strobeCnt, sc);
    readReg("R9 bad key read", 4'd3, 16'h0000, 24, 2'b11);

    // R10 mode pin
    modeDefault = 1'b1;
    repeat (2) @(negedge clk);
    model[3] = 16'h0303; model[7] = 16'h0707;
    for (int i = 0; i < 16; i++) chkReg("R10 defaults in mode", i);
    writeReg(4'd4, 16'h7777, 24, 2'b10, 1'b0);
    chkReg("R10 write ignored", 4);
    chk("R10 no strobe", strobeCnt, sc);
    modeDefault = 1'b0;
    repeat (2) @(negedge clk);
    chkReg("R10 defaults persist", 3);

    writeReg(4'd0, 16'hFFFF, 24, 2'b10, 1'b0);
    model[0] = 16'hFFFF;
    chkReg("R3 write addr0", 0);
    readReg("R4 addr0", 4'd0, 16'hFFFF, 24, 2'b10);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", expQ.size() + obsQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule